// File: doc/BRIEF.md
# Halt Wake-Up Controller

This block tracks whether the processor core is halted and decides how the core leaves that state. While the core runs, a one-cycle halt request stops the core clock. The chosen oscillator keeps running. The block then watches a set of interrupt sources, each with a request flag, a mask bit and a priority bit. It also watches a global interrupt enable and the in-service priority bit. Any unmasked request ends the halt. The block then emits a one-cycle release strobe tagged with a resume action: carry on at the next instruction, or enter interrupt servicing.

The reset input overrides everything. It ends a halt whatever the interrupt inputs are. It then runs an oscillator settling wait before the core clock is enabled again. The end of that wait is reported as a release strobe with the reset-processing action. The wait length depends on which oscillator is in use. The crystal uses a selectable count. The internal ring oscillator uses a fixed count. An oscillator-ready input gates the countdown.

Top module: `halt_wake_ctrl`

## Requirements
- R1: While `rst` is high at a rising edge, the following outputs are 0 after that edge: `halt_active`, `clk_run` and `rel_strobe`. `rel_action` is 0 (none).
- R2: With `xtal_sel`=1, the settle length N depends on `settle_sel`: 0 gives 2^11, 1 gives 2^13, 2 gives 2^14, 3 gives 2^15, and 4 to 7 give 2^16 cycles. `rel_strobe` is first high after the (N+1)th rising edge at which `rst` is low, with `osc_ready` held high.
- R3: With `xtal_sel`=0, the ring-oscillator settle length N is 17 cycles, with the same edge count as R2.
- R4: Only edges with `osc_ready` high, after the first edge out of reset, advance the settle count. The settle wait ends with `rel_strobe`=1, `rel_action`=3 (reset processing) and `clk_run`=1.
- R5: In the running state, a `halt_req` with no unmasked pending request gives `halt_active`=1 and `clk_run`=0 after the next edge.
- R6: While halted, a request whose mask bit is 1, or no request at all, leaves `halt_active` at 1 and `rel_strobe` at 0.
- R7: While halted, an unmasked request wakes the core on the next edge. If `gie`=0, the action is 1 (next instruction).
- R8: An unmasked request with `irq_lowpri`=0 and `gie`=1 gives action 2 (interrupt servicing), whatever `isp` is.
- R9: An unmasked request with `irq_lowpri`=1 and `gie`=1 gives action 2 only when `isp`=1. Otherwise it gives action 1.
- R10: When several unmasked requests are pending, action 2 is chosen if any one of them qualifies for servicing.
- R11: A `halt_req` made while an unmasked request is pending gives a release strobe on the next edge. `halt_active` is never raised.
- R12: `rel_strobe` lasts exactly one cycle. `rel_action` is 0 whenever `rel_strobe` is 0.
- R13: A reset arriving in the same cycle as an unmasked wake request while halted wins. No interrupt strobe is made, the halt ends, and the settle wait restarts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high reset; the core reset |
| halt_req | input | 1 | One-cycle halt request from the core |
| irq_flag | input | NUM_SRC | Interrupt request flags |
| irq_mask | input | NUM_SRC | Mask bits, 1 = masked |
| irq_lowpri | input | NUM_SRC | Priority bits, 1 = low priority |
| gie | input | 1 | Global interrupt enable |
| isp | input | 1 | In-service priority bit |
| xtal_sel | input | 1 | 1 = crystal clocks the core, 0 = ring oscillator |
| settle_sel | input | 3 | Crystal settle length select |
| osc_ready | input | 1 | Oscillator running; gates the settle count |
| halt_active | output | 1 | Core is halted |
| clk_run | output | 1 | Core clock enable |
| rel_strobe | output | 1 | One-cycle release pulse |
| rel_action | output | 2 | Resume action: 0 none, 1 next, 2 service, 3 reset |

## Verification
A reset and an interrupt wake can land on the same clock edge while the core is halted. The bench halts the core, then raises `rst` and an unmasked, servicing-qualified request in the same cycle. After that edge it requires no strobe, no halt and no clock enable. It then times the restarted settle wait, which must end with the reset action rather than the interrupt one.

// File: rtl/halt_wake_pkg.sv
package halt_wake_pkg;

    localparam int SETTLE_W = 17;

    typedef enum logic [1:0] {
        ACT_NONE  = 2'd0,
        ACT_NEXT  = 2'd1,
        ACT_ISR   = 2'd2,
        ACT_RESET = 2'd3
    } resume_act_e;

    typedef enum logic [1:0] {
        ST_RESET,
        ST_SETTLE,
        ST_RUN,
        ST_HALT
    } hw_state_e;

    typedef struct packed {
        logic wake;
        logic service;
    } wake_vote_t;

    function automatic logic [SETTLE_W-1:0] xtal_settle(input logic [2:0] sel);
        logic [SETTLE_W-1:0] r;
        r = '0;
        case (sel)
            3'd0:    r[11] = 1'b1;
            3'd1:    r[13] = 1'b1;
            3'd2:    r[14] = 1'b1;
            3'd3:    r[15] = 1'b1;
            default: r[16] = 1'b1;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/halt_wake_decode.sv
module halt_wake_decode
    import halt_wake_pkg::*;
#(
    parameter int NUM_SRC = 4
) (
    input  logic [NUM_SRC-1:0] irq_flag,
    input  logic [NUM_SRC-1:0] irq_mask,
    input  logic [NUM_SRC-1:0] irq_lowpri,
    input  logic               gie,
    input  logic               isp,
    output wake_vote_t         vote
);
    logic [NUM_SRC-1:0] wake_v;
    logic [NUM_SRC-1:0] svc_v;

    for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
        assign wake_v[i] = irq_flag[i] & ~irq_mask[i];
        // high priority needs only the global enable; low priority also needs isp
        assign svc_v[i]  = wake_v[i] & gie & (~irq_lowpri[i] | isp);
    end

    assign vote.wake    = |wake_v;
    assign vote.service = |svc_v;
endmodule

// File: rtl/halt_settle_timer.sv
module halt_settle_timer #(
    parameter int W = 17
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic [W-1:0] load_val,
    input  logic         tick,
    output logic         expire
);
    logic [W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
        end else if (load) begin
            cnt <= load_val;
        end else if (tick && cnt != '0) begin
            cnt <= cnt - 1'b1;
        end
    end

    assign expire = tick && (cnt == W'(1));
endmodule

// File: rtl/halt_wake_ctrl.sv
module halt_wake_ctrl
    import halt_wake_pkg::*;
#(
    parameter int NUM_SRC     = 4,
    parameter int RING_CYCLES = 17
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               halt_req,
    input  logic [NUM_SRC-1:0] irq_flag,
    input  logic [NUM_SRC-1:0] irq_mask,
    input  logic [NUM_SRC-1:0] irq_lowpri,
    input  logic               gie,
    input  logic               isp,
    input  logic               xtal_sel,
    input  logic [2:0]         settle_sel,
    input  logic               osc_ready,
    output logic               halt_active,
    output logic               clk_run,
    output logic               rel_strobe,
    output logic [1:0]         rel_action
);
    localparam int SW = SETTLE_W;

    hw_state_e     state;
    resume_act_e   act_q;
    logic          strobe_q;
    wake_vote_t    vote;
    logic          tmr_load;
    logic          tmr_tick;
    logic          tmr_expire;
    logic [SW-1:0] settle_len;
    resume_act_e   wake_act;

    halt_wake_decode #(.NUM_SRC(NUM_SRC)) u_decode (
        .irq_flag   (irq_flag),
        .irq_mask   (irq_mask),
        .irq_lowpri (irq_lowpri),
        .gie        (gie),
        .isp        (isp),
        .vote       (vote)
    );

    assign settle_len = xtal_sel ? xtal_settle(settle_sel) : SW'(RING_CYCLES);
    assign tmr_load   = (state == ST_RESET);
    assign tmr_tick   = (state == ST_SETTLE) && osc_ready;

    halt_settle_timer #(.W(SW)) u_timer (
        .clk      (clk),
        .rst      (rst),
        .load     (tmr_load),
        .load_val (settle_len),
        .tick     (tmr_tick),
        .expire   (tmr_expire)
    );

    assign wake_act = vote.service ? ACT_ISR : ACT_NEXT;

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= ST_RESET;
            strobe_q <= 1'b0;
            act_q    <= ACT_NONE;
        end else begin
            strobe_q <= 1'b0;
            act_q    <= ACT_NONE;
            case (state)
                ST_RESET: state <= ST_SETTLE;
                ST_SETTLE: begin
                    if (tmr_expire) begin
                        state    <= ST_RUN;
                        strobe_q <= 1'b1;
                        act_q    <= ACT_RESET;
                    end
                end
                ST_RUN: begin
                    if (halt_req) begin
                        if (vote.wake) begin
                            strobe_q <= 1'b1;
                            act_q    <= wake_act;
                        end else begin
                            state <= ST_HALT;
                        end
                    end
                end
                ST_HALT: begin
                    if (vote.wake) begin
                        state    <= ST_RUN;
                        strobe_q <= 1'b1;
                        act_q    <= wake_act;
                    end
                end
                default: state <= ST_RESET;
            endcase
        end
    end

    assign halt_active = (state == ST_HALT);
    assign clk_run     = (state == ST_RUN);
    assign rel_strobe  = strobe_q;
    assign rel_action  = act_q;
endmodule

// File: rtl/halt_wake_checker.sv
module halt_wake_checker #(
    parameter int NUM_SRC = 4
) (
    input logic               clk,
    input logic               rst,
    input logic [NUM_SRC-1:0] irq_flag,
    input logic [NUM_SRC-1:0] irq_mask,
    input logic               halt_active,
    input logic               clk_run,
    input logic               rel_strobe,
    input logic [1:0]         rel_action
);
    logic any_unmasked;
    assign any_unmasked = |(irq_flag & ~irq_mask);

    assert_reset_quiet_R1: assert property (@(posedge clk)
        $fell(rst) |-> (!clk_run && !halt_active && !rel_strobe));

    assert_halt_stops_clock_R5: assert property (@(posedge clk) disable iff (rst)
        halt_active |-> !clk_run);

    assert_masked_hold_R6: assert property (@(posedge clk) disable iff (rst)
        (halt_active && !any_unmasked) |=> (halt_active && !rel_strobe));

    assert_unmasked_wake_R7: assert property (@(posedge clk) disable iff (rst)
        (halt_active && any_unmasked) |=> (rel_strobe && !halt_active && clk_run));

    assert_strobe_tagged_R12: assert property (@(posedge clk) disable iff (rst)
        rel_strobe |-> (rel_action != 2'd0 && clk_run));

    assert_idle_no_action_R12: assert property (@(posedge clk) disable iff (rst)
        !rel_strobe |-> (rel_action == 2'd0));
endmodule

bind halt_wake_ctrl halt_wake_checker #(.NUM_SRC(NUM_SRC)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .irq_flag    (irq_flag),
    .irq_mask    (irq_mask),
    .halt_active (halt_active),
    .clk_run     (clk_run),
    .rel_strobe  (rel_strobe),
    .rel_action  (rel_action)
);

// File: tb/sim_halt_wake_ctrl.sv
`timescale 1ns/1ps
module sim_halt_wake_ctrl;
    localparam int NS = 4;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          halt_req = 1'b0;
    logic [NS-1:0] irq_flag = '0;
    logic [NS-1:0] irq_mask = '0;
    logic [NS-1:0] irq_lowpri = '0;
    logic          gie = 1'b0;
    logic          isp = 1'b0;
    logic          xtal_sel = 1'b0;
    logic [2:0]    settle_sel = 3'd0;
    logic          osc_ready = 1'b1;
    logic          halt_active;
    logic          clk_run;
    logic          rel_strobe;
    logic [1:0]    rel_action;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    halt_wake_ctrl #(.NUM_SRC(NS), .RING_CYCLES(17)) u0 (
        .clk(clk), .rst(rst), .halt_req(halt_req), .irq_flag(irq_flag),
        .irq_mask(irq_mask), .irq_lowpri(irq_lowpri), .gie(gie), .isp(isp),
        .xtal_sel(xtal_sel), .settle_sel(settle_sel), .osc_ready(osc_ready),
        .halt_active(halt_active), .clk_run(clk_run),
        .rel_strobe(rel_strobe), .rel_action(rel_action)
    );

    // {flag[15:12], mask[11:8], lowpri[7:4], gie[3], isp[2], expected action[1:0]}
    localparam int NV = 12;
    localparam logic [15:0] VEC [NV] = '{
        {4'b0001, 4'b0000, 4'b0000, 1'b0, 1'b0, 2'd1},  // R7
        {4'b0001, 4'b0000, 4'b0000, 1'b1, 1'b0, 2'd2},  // R8
        {4'b0001, 4'b0000, 4'b0000, 1'b1, 1'b1, 2'd2},  // R8
        {4'b0001, 4'b0000, 4'b0001, 1'b0, 1'b1, 2'd1},  // R7
        {4'b0001, 4'b0000, 4'b0001, 1'b1, 1'b0, 2'd1},  // R9
        {4'b0001, 4'b0000, 4'b0001, 1'b1, 1'b1, 2'd2},  // R9
        {4'b0001, 4'b0001, 4'b0000, 1'b1, 1'b1, 2'd0},  // R6
        {4'b1111, 4'b1111, 4'b0000, 1'b1, 1'b1, 2'd0},  // R6
        {4'b0110, 4'b0010, 4'b0110, 1'b1, 1'b0, 2'd1},  // R10
        {4'b1010, 4'b0000, 4'b1000, 1'b1, 1'b0, 2'd2},  // R10
        {4'b0000, 4'b1111, 4'b0000, 1'b1, 1'b1, 2'd0},  // R6
        {4'b1000, 4'b0000, 4'b1000, 1'b1, 1'b1, 2'd2}   // R9
    };
    localparam int VREQ [NV] = '{7, 8, 8, 7, 9, 9, 6, 6, 10, 10, 6, 9};

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    // Assert reset for one edge, release it and count edges to the strobe.
    task automatic settle_run(input bit xs, input logic [2:0] sel, input int n,
                              input int stall, input string req);
        int k;
        int exp_k;
        @(negedge clk);
        rst = 1'b1; xtal_sel = xs; settle_sel = sel;
        step();
        rst = 1'b0;
        osc_ready = (stall == 0);
        exp_k = ((stall == 0) ? 1 : stall) + n;
        k = 0;
        while (k < exp_k + 8) begin
            @(posedge clk);
            k++;
            @(negedge clk);
            if (rel_strobe) break;
            osc_ready = (k >= stall);
        end
        osc_ready = 1'b1;
        check({req, " settle edges"}, k, exp_k);
        check({req, " R4 reset action"}, rel_action, 3);
        check({req, " R4 clk_run"}, clk_run, 1);
        step();
        check({req, " R12 strobe width"}, rel_strobe, 0);
    endtask

    initial begin
        repeat (195000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++; fails++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        // R1 reset state
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R1 halt_active", halt_active, 0);
        check("R1 clk_run", clk_run, 0);
        check("R1 rel_strobe", rel_strobe, 0);
        check("R1 rel_action", rel_action, 0);

        // R3 ring oscillator settle
        settle_run(1'b0, 3'd0, 17, 0, "R3");

        // release table
        for (int v = 0; v < NV; v++) begin
            string tag;
            tag = $sformatf("R%0d vec%0d", VREQ[v], v);
            irq_flag = '0; irq_mask = '0; irq_lowpri = '0; gie = 0; isp = 0;
            halt_req = 1'b1;
            step();
            halt_req = 1'b0;
            check({tag, " R5 halt_active"}, halt_active, 1);
            check({tag, " R5 clk_run"}, clk_run, 0);
            irq_flag   = VEC[v][15:12];
            irq_mask   = VEC[v][11:8];
            irq_lowpri = VEC[v][7:4];
            gie        = VEC[v][3];
            isp        = VEC[v][2];
            step();
            if (VEC[v][1:0] == 2'd0) begin
                check({tag, " R6 stays halted"}, halt_active, 1);
                check({tag, " R6 no strobe"}, rel_strobe, 0);
                step();
                check({tag, " R6 still halted"}, halt_active, 1);
                irq_flag = 4'b0001; irq_mask = '0; irq_lowpri = '0; gie = 0;
                step();
                check({tag, " R7 clean wake"}, rel_action, 1);
            end else begin
                check({tag, " strobe"}, rel_strobe, 1);
                check({tag, " action"}, rel_action, int'(VEC[v][1:0]));
                check({tag, " halt cleared"}, halt_active, 0);
            end
            irq_flag = '0;
            step();
            check({tag, " R12 one cycle"}, rel_strobe, 0);
            check({tag, " R12 action idle"}, rel_action, 0);
        end

        // R11 halt request with a pending unmasked request
        irq_flag = 4'b0100; irq_mask = 4'b0000; irq_lowpri = 4'b0000; gie = 1; isp = 0;
        halt_req = 1'b1;
        step();
        halt_req = 1'b0;
        check("R11 strobe", rel_strobe, 1);
        check("R11 action", rel_action, 2);
        check("R11 never halted", halt_active, 0);
        irq_flag = '0;
        step();

        // R13 reset and wake in the same cycle while halted
        halt_req = 1'b1;
        step();
        halt_req = 1'b0;
        check("R13 halted first", halt_active, 1);
        rst = 1'b1;
        irq_flag = 4'b0001; gie = 1; isp = 1;
        step();
        check("R13 no strobe", rel_strobe, 0);
        check("R13 halt ended", halt_active, 0);
        check("R13 clock held", clk_run, 0);
        irq_flag = '0;
        settle_run(1'b0, 3'd0, 17, 0, "R13");

        // R4 oscillator-ready stall
        settle_run(1'b0, 3'd0, 17, 10, "R4");

        // R2 crystal settle lengths
        settle_run(1'b1, 3'd0, 2048, 0, "R2 sel0");
        settle_run(1'b1, 3'd1, 8192, 0, "R2 sel1");
        settle_run(1'b1, 3'd2, 16384, 0, "R2 sel2");
        settle_run(1'b1, 3'd3, 32768, 0, "R2 sel3");
        settle_run(1'b1, 3'd4, 65536, 0, "R2 sel4");

        if (!done) begin
            done = 1'b1;
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end
endmodule